// File: doc/BRIEF.md
# Thermometer-Coded Octal Token Counter

The block keeps a prepaid token balance as five radix-8 digits. Each digit is a thermometer field whose value is simply how many of its bits are set, so a digit can reach eight (all ones) and one balance may be written in several ways. The balance only ever goes down. A decrement clears the topmost set bit of the least significant digit. When that digit is empty, the block first takes one unit from the nearest non-empty higher digit and spreads it over the lower digits. Each step clears bits or sets bits, never both in one digit, the way an erase-only or program-only memory would be written.

A personalization load writes the whole field image at once. The block decodes the image into a binary token total, flags a zero balance, and flags any digit whose bit pattern is not a legal thermometer code.

Top module: `tok_counter`

## Requirements
- R1: After reset all field bits are 0, `tokens_o` is 0, `zero_o` is 1 and `busy_o`, `done_o`, `err_o` are 0.
- R2: The field image packs the most significant digit (7 bits) at bits [6:0], then the three middle digits of 8 bits at [14:7], [22:15], [30:23], and the least significant digit at [38:31]. Inside a digit, bit 0 is the first bit to fill. A digit's value is its count of set bits, and `tokens_o` = d4*4096 + d3*512 + d2*64 + d1*8 + d0. For example, digits 3,0,7,1,3 give 12747, and digits 0,0,5,0,0, 0,0,4,8,0 and 0,0,4,7,8 all give 320.
- R3: A high `load_i` copies `load_bits_i` into the field on the next edge. It takes priority over a decrement in the same cycle, and it ends a decrement that is in progress without raising `done_o`.
- R4: When the balance is nonzero and the lowest digit is nonzero, a decrement accepted at one edge clears that digit's highest set bit at that same edge. `done_o` is high for the following cycle and `busy_o` stays low.
- R5: When the lowest digit is zero, a decrement takes three edges. The first clears the highest set bit of the lowest non-empty higher digit k. The second sets each digit strictly between 0 and k to seven ones and sets digit 0 to eight ones. The third clears the top bit of digit 0. `busy_o` is high for the two cycles after acceptance, and `done_o` follows the third edge.
- R6: A decrement requested while the balance is zero leaves the field unchanged and raises `err_o` for the following cycle. `done_o` stays low.
- R7: A decrement strobe seen while `busy_o` is high is ignored: the balance drops by exactly one for the operation in progress.
- R8: `corrupt_o` is high whenever any digit holds a pattern other than a run of ones starting at its bit 0.
- R9: Every completed decrement lowers `tokens_o` by exactly one, and `zero_o` is high exactly when `tokens_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the field image |
| load_bits_i | input | 39 | Field image to load |
| dec_i | input | 1 | Decrement request |
| field_o | output | 39 | Raw digit field bits |
| tokens_o | output | 16 | Binary token total |
| zero_o | output | 1 | Balance is zero |
| corrupt_o | output | 1 | A digit is not a thermometer code |
| busy_o | output | 1 | Borrow sequence in progress |
| done_o | output | 1 | Decrement completed last edge |
| err_o | output | 1 | Decrement refused at zero balance |

## Verification
A load and a decrement can arrive in the same cycle. This can happen from idle, and it can also happen while a borrow sequence is partway through. The bench provokes the first case by asserting both strobes together at idle. It provokes the second by raising the load one cycle after a borrow is accepted. In both cases the field must equal the loaded image on the next cycle, with `done_o` and `err_o` low and `busy_o` cleared.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DEC  = 2'd2
  } tc_state_e;
endpackage

// File: rtl/tc_digit.sv
module tc_digit #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] val_o,
  output logic          nz_o,
  output logic          therm_ok_o,
  output logic [W-1:0]  clr_o
);
  logic [W:0] ext;
  logic       found;

  assign ext        = {1'b0, bits_i};
  assign therm_ok_o = ((ext + 1'b1) & ext) == '0;
  assign nz_o       = |bits_i;

  always_comb begin
    val_o = '0;
    for (int k = 0; k < W; k++) val_o = val_o + CW'(bits_i[k]);
  end

  // clear the highest set bit
  always_comb begin
    clr_o = bits_i;
    found = 1'b0;
    for (int k = W-1; k >= 0; k--) begin
      if (!found && bits_i[k]) begin
        clr_o[k] = 1'b0;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic         tot_nz_i,
  input  logic [N-1:0] nz_i,
  output logic         do_clr_o,
  output logic         do_fill_o,
  output logic         do_dec0_o,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] below_o,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o
);
  tc_state_e    st_q, st_d;
  logic [N-1:0] below_q;
  logic         err_set;

  // lowest non-empty digit above digit 0
  always_comb begin
    sel_o = '0;
    for (int i = N-1; i >= 1; i--) if (nz_i[i]) sel_o = N'(1) << i;
  end

  always_comb begin
    st_d      = st_q;
    do_clr_o  = 1'b0;
    do_fill_o = 1'b0;
    do_dec0_o = 1'b0;
    err_set   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!load_i && dec_i) begin
        if (!tot_nz_i)    err_set   = 1'b1;
        else if (nz_i[0]) do_dec0_o = 1'b1;
        else begin
          do_clr_o = 1'b1;
          st_d     = ST_FILL;
        end
      end
      ST_FILL: begin
        if (load_i) st_d = ST_IDLE;
        else begin
          do_fill_o = 1'b1;
          st_d      = ST_DEC;
        end
      end
      ST_DEC: begin
        st_d = ST_IDLE;
        if (!load_i) do_dec0_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      below_q <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= do_dec0_o;
      err_o  <= err_set;
      if (do_clr_o) below_q <= sel_o - 1'b1;
    end
  end

  assign below_o = below_q;
  assign busy_o  = st_q != ST_IDLE;
endmodule

// File: rtl/tok_counter.sv
module tok_counter #(
  parameter  int NUM_DIGITS = 5,
  parameter  int DIG_W      = 8,
  parameter  int TOP_W      = 7,
  localparam int FIELD_W    = (NUM_DIGITS-1)*DIG_W + TOP_W,
  localparam int RAD_SH     = $clog2(DIG_W),
  localparam int TOK_W      = RAD_SH*NUM_DIGITS + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_bits_i,
  input  logic               dec_i,
  output logic [FIELD_W-1:0] field_o,
  output logic [TOK_W-1:0]   tokens_o,
  output logic               zero_o,
  output logic               corrupt_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int CW = $clog2(DIG_W+1);

  logic [FIELD_W-1:0]    field_q, field_d;
  logic [NUM_DIGITS-1:0] nz, ok, sel, below;
  logic [CW-1:0]         val [NUM_DIGITS];
  logic                  do_clr, do_fill, do_dec0;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    localparam int W   = (i == NUM_DIGITS-1) ? TOP_W : DIG_W;
    localparam int OFF = (i == NUM_DIGITS-1) ? 0 : (NUM_DIGITS-1-i)*DIG_W - (DIG_W-TOP_W);
    localparam logic [W-1:0] FILL_V = (i == 0) ? {W{1'b1}} : ({W{1'b1}} >> 1);

    logic [W-1:0]  cur, clr, nxt;
    logic [CW-1:0] v;

    assign cur = field_q[OFF +: W];

    tc_digit #(.W(W), .CW(CW)) i_digit (
      .bits_i     (cur),
      .val_o      (v),
      .nz_o       (nz[i]),
      .therm_ok_o (ok[i]),
      .clr_o      (clr)
    );

    always_comb begin
      if (load_i)                      nxt = load_bits_i[OFF +: W];
      else if (do_clr && sel[i])       nxt = clr;
      else if (do_fill && below[i])    nxt = FILL_V;
      else if (do_dec0 && (i == 0))    nxt = clr;
      else                             nxt = cur;
    end

    assign field_d[OFF +: W] = nxt;
    assign val[i]            = v;
  end

  always_comb begin
    tokens_o = '0;
    for (int i = 0; i < NUM_DIGITS; i++)
      tokens_o = tokens_o + (TOK_W'(val[i]) << (RAD_SH*i));
  end

  assign zero_o    = tokens_o == '0;
  assign corrupt_o = ~&ok;
  assign field_o   = field_q;

  tc_ctrl #(.N(NUM_DIGITS)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .dec_i     (dec_i),
    .tot_nz_i  (|nz),
    .nz_i      (nz),
    .do_clr_o  (do_clr),
    .do_fill_o (do_fill),
    .do_dec0_o (do_dec0),
    .sel_o     (sel),
    .below_o   (below),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_q <= '0;
    else         field_q <= field_d;
  end
endmodule

// File: rtl/tok_counter_chk.sv
module tok_counter_chk #(
  parameter int FIELD_W = 39,
  parameter int TOK_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [FIELD_W-1:0] load_bits_i,
  input logic               dec_i,
  input logic [FIELD_W-1:0] field_o,
  input logic [TOK_W-1:0]   tokens_o,
  input logic               zero_o,
  input logic               corrupt_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o
);
  logic [TOK_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= '0;
    else if (dec_i && !busy_o && !load_i && !zero_o) start_q <= tokens_o;
  end

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (field_o == $past(load_bits_i)) && !busy_o && !done_o);

  a_r9_net_minus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tokens_o == start_q - 1'b1);

  a_r6_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(field_o) && !done_o);

  a_r6_err_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(zero_o) && zero_o);

  a_r5_busy_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !load_i) |=> busy_o);
endmodule

bind tok_counter tok_counter_chk #(.FIELD_W(FIELD_W), .TOK_W(TOK_W)) i_chk (.*);

// File: tb/test_tok_counter.sv
module test_tok_counter;
  localparam int FW = 39;
  localparam int TW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [FW-1:0] load_bits_i = '0;
  logic          dec_i = 1'b0;
  logic [FW-1:0] field_o;
  logic [TW-1:0] tokens_o;
  logic          zero_o, corrupt_o, busy_o, done_o, err_o;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #10 clk_i = ~clk_i;

  tok_counter i_tok_counter (.*);

  function automatic logic [FW-1:0] mk(int d4, int d3, int d2, int d1, int d0);
    logic [FW-1:0] f = '0;
    f[6:0]   = 7'((1 << d4) - 1);
    f[14:7]  = 8'((1 << d3) - 1);
    f[22:15] = 8'((1 << d2) - 1);
    f[30:23] = 8'((1 << d1) - 1);
    f[38:31] = 8'((1 << d0) - 1);
    return f;
  endfunction

  function automatic int tk(int d4, int d3, int d2, int d1, int d0);
    return d4*4096 + d3*512 + d2*64 + d1*8 + d0;
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic load(logic [FW-1:0] v);
    @(negedge clk_i); load_i = 1'b1; load_bits_i = v;
    @(negedge clk_i); load_i = 1'b0;
  endtask

  task automatic pulse_dec();
    @(negedge clk_i); dec_i = 1'b1;
    @(negedge clk_i); dec_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 field", field_o, 0);
    check("R1 tokens", tokens_o, 0);
    check("R1 zero", zero_o, 1);
    check("R1 busy/done/err", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_decode();
    load(mk(3, 0, 7, 1, 3));
    check("R2 example", tokens_o, 12747);
    check("R9 zero low", zero_o, 0);
    load(mk(0, 0, 5, 0, 0)); check("R2 320 a", tokens_o, 320);
    load(mk(0, 0, 4, 8, 0)); check("R2 320 b", tokens_o, 320);
    load(mk(0, 0, 4, 7, 8)); check("R2 320 c", tokens_o, 320);
    check("R8 clean", corrupt_o, 0);
  endtask

  task automatic t_fast();
    load(mk(3, 0, 7, 1, 3));
    pulse_dec();
    check("R4 field", field_o, mk(3, 0, 7, 1, 2));
    check("R4 done", done_o, 1);
    check("R4 busy", busy_o, 0);
    check("R9 minus one", tokens_o, 12746);
    load(mk(0, 0, 0, 0, 8));
    pulse_dec();
    check("R4 from eight", field_o, mk(0, 0, 0, 0, 7));
  endtask

  task automatic t_borrow();
    load(mk(0, 0, 5, 0, 0));
    pulse_dec();
    check("R5 busy c1", busy_o, 1);
    check("R5 clr", field_o, mk(0, 0, 4, 0, 0));
    @(negedge clk_i);
    check("R5 busy c2", busy_o, 1);
    check("R5 fill", field_o, mk(0, 0, 4, 7, 8));
    @(negedge clk_i);
    check("R5 done", {busy_o, done_o}, 2'b01);
    check("R5 final", field_o, mk(0, 0, 4, 7, 7));
    check("R9 319", tokens_o, 319);
    load(mk(1, 0, 0, 0, 0));
    pulse_dec(); @(negedge clk_i); @(negedge clk_i);
    check("R5 far", field_o, mk(0, 7, 7, 7, 7));
    check("R9 4095", tokens_o, tk(0, 7, 7, 7, 7));
  endtask

  task automatic t_zero_err();
    load('0);
    pulse_dec();
    check("R6 err", {err_o, done_o}, 2'b10);
    check("R6 field", field_o, 0);
    check("R9 zero", zero_o, 1);
  endtask

  task automatic t_busy_ignore();
    load(mk(0, 0, 5, 0, 0));
    pulse_dec();
    dec_i = 1'b1;
    @(negedge clk_i); dec_i = 1'b0;
    @(negedge clk_i);
    check("R7 done", done_o, 1);
    @(negedge clk_i);
    check("R7 once", tokens_o, 319);
    check("R7 no extra", {busy_o, done_o}, 0);
  endtask

  task automatic t_load_collide();
    load(mk(0, 0, 0, 0, 3));
    @(negedge clk_i); load_i = 1'b1; dec_i = 1'b1; load_bits_i = mk(1, 1, 1, 1, 1);
    @(negedge clk_i); load_i = 1'b0; dec_i = 1'b0;
    check("R3 load wins", field_o, mk(1, 1, 1, 1, 1));
    check("R3 no done", {busy_o, done_o, err_o}, 0);
    load(mk(0, 0, 5, 0, 0));
    pulse_dec();
    load_i = 1'b1; load_bits_i = mk(2, 2, 2, 2, 2);
    @(negedge clk_i); load_i = 1'b0;
    check("R3 abort", field_o, mk(2, 2, 2, 2, 2));
    check("R3 abort idle", {busy_o, done_o}, 0);
    @(negedge clk_i);
    check("R3 abort quiet", {done_o, field_o == mk(2, 2, 2, 2, 2)}, 2'b01);
  endtask

  task automatic t_corrupt();
    logic [FW-1:0] v = '0;
    v[17] = 1'b1; v[15] = 1'b1;
    load(v);
    check("R8 flag", corrupt_o, 1);
    check("R2 popcount", tokens_o, 128);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_fast();
    t_borrow();
    t_zero_err();
    t_busy_ignore();
    t_load_collide();
    t_corrupt();
    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule